// File: doc/BRIEF.md
# Circular I/Q Sample Buffer with Block-Ready Interrupt

This block sits between a front-end that delivers one complex sample per write strobe and a baseband processor that works on fixed-size blocks. Each sample carries an 8-bit in-phase part and an 8-bit quadrature part. The pair is stored as one 16-bit word in a circular memory whose depth is a power of two. The front-end keeps writing while the processor drains a block, so the memory must hold at least two blocks.

The block keeps a write pointer, a read pointer and an unread count. A level interrupt is raised while at least one block of unread samples is waiting. The processor then issues one read request per sample. Each request returns the oldest unread word one cycle later, so every service picks up where the previous one stopped. A write that finds the memory full is dropped and sets a sticky overrun flag. A read of an empty buffer returns zero and sets a sticky underflow flag. Both flags clear on a one-cycle clear pulse.

Top module: `iq_ring_buffer`

## Requirements
- R1: A stored sample is returned as one 16-bit word, with the in-phase byte in bits 15:8 and the quadrature byte in bits 7:0.
- R2: `fill_level` equals accepted writes minus accepted reads, counted since reset. A cycle in which both a write and a read are accepted leaves it unchanged. It never exceeds DEPTH.
- R3: `blk_irq` is high exactly while `fill_level` is at least BLOCK_LEN. It drops in the cycle after a read brings the count below BLOCK_LEN.
- R4: A read request accepted at a clock edge gives `rd_valid` high one cycle later. The data is the oldest unread sample, in write order, and this order holds across pointer wraparound.
- R5: A write strobe seen while `fill_level` equals DEPTH is dropped and leaves the stored data and the count untouched. It sets `overrun`, which then stays high.
- R6: A `flag_clr` pulse clears `overrun` and `underflow`. When a new overrun or underflow happens in the same cycle as the pulse, the flag stays set.
- R7: A read request while `fill_level` is zero still gives `rd_valid` one cycle later, with `rd_data` equal to zero. It sets the sticky `underflow` flag and does not change the count.
- R8: After a synchronous active-low reset, `fill_level` is zero and `blk_irq`, `overrun`, `underflow` and `rd_valid` are low.
- R9: Writes go on being accepted while a block is being read. With one write and one read per cycle, no sample is lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe from the front-end |
| wr_i | input | 8 | In-phase part of the sample |
| wr_q | input | 8 | Quadrature part of the sample |
| rd_req | input | 1 | Read request from the processor |
| flag_clr | input | 1 | Clears the sticky overrun and underflow flags |
| rd_valid | output | 1 | Read data is valid (one cycle after the request) |
| rd_data | output | 16 | Returned sample {I, Q}, zero on an empty read |
| fill_level | output | $clog2(DEPTH)+1 | Number of unread samples |
| blk_irq | output | 1 | Level interrupt: at least one block is waiting |
| overrun | output | 1 | Sticky: a write was dropped because the buffer was full |
| underflow | output | 1 | Sticky: a read found the buffer empty |

## Verification
The buffer is driven with four stimulus patterns:
- Writes alone, which step the count across the block threshold and show the interrupt edge.
- One write and one read per cycle during a block service, which separates a correct combined count update from one that handles only one side.
- Writing past full, with and without a simultaneous read and a clear pulse, which shows whether a dropped sample corrupts the data and whether the flag set takes priority over the clear.
- Draining more words than are stored, after the pointers have wrapped, which checks both wraparound ordering and the zero data returned by an empty read.

// File: rtl/iqbuf_pkg.sv
// Package: shared sample format for the circular I/Q buffer.
// Assumes both sample parts use the same width; the packed word puts I on top.
package iqbuf_pkg;
    localparam int IQ_W   = 8;
    localparam int WORD_W = 2 * IQ_W;

    typedef struct packed {
        logic [IQ_W-1:0] i_part;
        logic [IQ_W-1:0] q_part;
    } iq_word_t;
endpackage

// File: rtl/iqbuf_ctrl.sv
// Module: pointer, count and flag control of the circular buffer.
// Decides whether a write or a read is accepted this cycle. Keeps the two
// pointers and the unread count, and the sticky overrun and underflow flags.
// Assumes DEPTH is a power of two, so the pointers wrap by natural overflow.
module iqbuf_ctrl #(
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       rd_req,
    input  logic                       flag_clr,
    output logic                       wr_acc,
    output logic                       rd_acc,
    output logic [$clog2(DEPTH)-1:0]   wr_ptr,
    output logic [$clog2(DEPTH)-1:0]   rd_ptr,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       overrun,
    output logic                       underflow
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic is_full;
    logic is_empty;

    // Purpose: accept a write only when there is space, and a read only when data is stored.
    always_comb begin
        is_full  = (count == FULL_CNT);
        is_empty = (count == '0);
        wr_acc   = wr_en && !is_full;
        rd_acc   = rd_req && !is_empty;
    end

    // Purpose: move the pointers and keep the unread count for both sides at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_acc) wr_ptr <= wr_ptr + PTR_W'(1);
            if (rd_acc) rd_ptr <= rd_ptr + PTR_W'(1);
            count <= count + CNT_W'(wr_acc) - CNT_W'(rd_acc);
        end
    end

    // Purpose: sticky error flags; a new event wins over the clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun   <= 1'b0;
            underflow <= 1'b0;
        end else begin
            overrun   <= (overrun && !flag_clr) || (wr_en && is_full);
            underflow <= (underflow && !flag_clr) || (rd_req && is_empty);
        end
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    assert_both_keep_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && rd_acc) |=> (count == $past(count)));

    assert_drop_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_full && !rd_req) |=> (overrun && count == FULL_CNT));

    assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !flag_clr) |=> overrun);

    assert_underflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !flag_clr) |=> underflow);
endmodule

// File: rtl/iqbuf_store.sv
// Module: sample storage with a registered read port.
// Writes the packed word at the write pointer. A read request gives
// rd_valid one cycle later. Its data is the word at the read pointer
// when the read was accepted, or zero when the buffer was empty.
// Assumes the controller never accepts a write into an unread location.
module iqbuf_store #(
    parameter int DEPTH = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_acc,
    input  logic [$clog2(DEPTH)-1:0]      wr_ptr,
    input  iqbuf_pkg::iq_word_t           wr_word,
    input  logic                          rd_req,
    input  logic                          rd_acc,
    input  logic [$clog2(DEPTH)-1:0]      rd_ptr,
    output logic                          rd_valid,
    output iqbuf_pkg::iq_word_t           rd_word
);
    iqbuf_pkg::iq_word_t mem [DEPTH];

    // Purpose: store an accepted sample.
    always_ff @(posedge clk) begin
        if (wr_acc) mem[wr_ptr] <= wr_word;
    end

    // Purpose: register the read result; an empty read returns zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_word  <= '0;
        end else begin
            rd_valid <= rd_req;
            rd_word  <= rd_acc ? mem[rd_ptr] : '0;
        end
    end

    assert_read_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    assert_idle_no_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);
endmodule

// File: rtl/iqbuf_irq.sv
// Module: block-ready interrupt.
// Raises a level interrupt while the unread count is at least BLOCK_LEN.
// Assumes the count is the registered value from the controller.
module iqbuf_irq #(
    parameter int DEPTH     = 32,
    parameter int BLOCK_LEN = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(DEPTH):0]    count,
    input  logic                      wr_acc,
    input  logic                      rd_acc,
    output logic                      blk_irq
);
    localparam int CNT_W = $clog2(DEPTH) + 1;
    localparam logic [CNT_W-1:0] THRESH = CNT_W'(BLOCK_LEN);

    // Purpose: compare the unread count with one block.
    always_comb begin
        blk_irq = (count >= THRESH);
    end

    assert_irq_rise_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blk_irq) |-> ($past(wr_acc) && !$past(rd_acc)));

    assert_irq_fall_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blk_irq) |-> ($past(rd_acc) && !$past(wr_acc)));
endmodule

// File: rtl/iq_ring_buffer.sv
// Module: top of the circular I/Q sample buffer with block-ready interrupt.
// The front-end writes one complex sample per strobe. The processor reads
// one sample per request with one cycle of latency. Overrun and underflow
// are flagged and held.
// Assumes DEPTH is a power of two and at least 2*BLOCK_LEN.
module iq_ring_buffer #(
    parameter int DEPTH     = 32,
    parameter int BLOCK_LEN = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [7:0]                wr_i,
    input  logic [7:0]                wr_q,
    input  logic                      rd_req,
    input  logic                      flag_clr,
    output logic                      rd_valid,
    output logic [15:0]               rd_data,
    output logic [$clog2(DEPTH):0]    fill_level,
    output logic                      blk_irq,
    output logic                      overrun,
    output logic                      underflow
);
    localparam int PTR_W = $clog2(DEPTH);

    logic                 wr_acc;
    logic                 rd_acc;
    logic [PTR_W-1:0]     wr_ptr;
    logic [PTR_W-1:0]     rd_ptr;
    iqbuf_pkg::iq_word_t  wr_word;
    iqbuf_pkg::iq_word_t  rd_word;

    // Purpose: pack the incoming sample and present the read word.
    always_comb begin
        wr_word.i_part = wr_i;
        wr_word.q_part = wr_q;
        rd_data        = rd_word;
    end

    iqbuf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_req    (rd_req),
        .flag_clr  (flag_clr),
        .wr_acc    (wr_acc),
        .rd_acc    (rd_acc),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .count     (fill_level),
        .overrun   (overrun),
        .underflow (underflow)
    );

    iqbuf_store #(.DEPTH(DEPTH)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_acc   (wr_acc),
        .wr_ptr   (wr_ptr),
        .wr_word  (wr_word),
        .rd_req   (rd_req),
        .rd_acc   (rd_acc),
        .rd_ptr   (rd_ptr),
        .rd_valid (rd_valid),
        .rd_word  (rd_word)
    );

    iqbuf_irq #(.DEPTH(DEPTH), .BLOCK_LEN(BLOCK_LEN)) irq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .count   (fill_level),
        .wr_acc  (wr_acc),
        .rd_acc  (rd_acc),
        .blk_irq (blk_irq)
    );

    assert_empty_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && fill_level == '0) |=> (rd_valid && rd_data == 16'h0000 && underflow));
endmodule

// File: tb/iq_ring_buffer_tb_top.sv
// Bench: scoreboard for the circular I/Q buffer. The driver task keeps a
// reference queue of stored samples and pushes each expected read word.
// A monitor pops one expected word for every rd_valid it sees.
module iq_ring_buffer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;
    localparam int BLOCK_LEN  = 8;
    localparam int CNT_W      = $clog2(DEPTH) + 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             wr_en, rd_req, flag_clr;
    logic [7:0]       wr_i, wr_q;
    logic             rd_valid;
    logic [15:0]      rd_data;
    logic [CNT_W-1:0] fill_level;
    logic             blk_irq, overrun, underflow;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [15:0] store_q[$];
    logic [15:0] exp_q[$];
    int  m_count = 0;
    bit  m_ovr = 0, m_udf = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iq_ring_buffer #(.DEPTH(DEPTH), .BLOCK_LEN(BLOCK_LEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_i(wr_i), .wr_q(wr_q),
        .rd_req(rd_req), .flag_clr(flag_clr), .rd_valid(rd_valid),
        .rd_data(rd_data), .fill_level(fill_level), .blk_irq(blk_irq),
        .overrun(overrun), .underflow(underflow)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: compare each returned word with the scoreboard (R1 packing, R4 order, R7 zero).
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) check("R4 unexpected rd_valid", 1, 0);
            else check("R1/R4 rd_data", int'(rd_data), int'(exp_q.pop_front()));
        end
    end

    // Driver: called at a negedge. Checks the levels left by the previous edge,
    // then drives one cycle and updates the reference model.
    task automatic cyc(input bit w, input logic [7:0] i, input logic [7:0] q,
                       input bit r, input bit c);
        check("R2 fill_level", int'(fill_level), m_count);
        check("R3 blk_irq", int'(blk_irq), int'(m_count >= BLOCK_LEN));
        check("R5/R6 overrun", int'(overrun), int'(m_ovr));
        check("R6/R7 underflow", int'(underflow), int'(m_udf));
        wr_en = w; wr_i = i; wr_q = q; rd_req = r; flag_clr = c;
        if (c) begin m_ovr = 0; m_udf = 0; end
        if (r) begin
            if (m_count > 0) exp_q.push_back(store_q.pop_front());
            else begin exp_q.push_back(16'h0000); m_udf = 1; end
        end
        if (w) begin
            if (m_count < DEPTH || (r && m_count == 0)) store_q.push_back({i, q});
            else m_ovr = 1;
        end
        m_count = store_q.size();
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    int n = 0;
    initial begin
        rst_n = 0; wr_en = 0; rd_req = 0; flag_clr = 0; wr_i = 0; wr_q = 0;
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 fill_level", int'(fill_level), 0);
        check("R8 blk_irq", int'(blk_irq), 0);
        check("R8 overrun", int'(overrun), 0);
        check("R8 underflow", int'(underflow), 0);
        check("R8 rd_valid", int'(rd_valid), 0);
        rst_n = 1;

        // R3: fill one below the threshold, then reach it.
        for (int k = 0; k < BLOCK_LEN; k++) begin cyc(1, 8'(n), 8'(8'hA0 + n), 0, 0); n++; end
        cyc(0, 0, 0, 0, 0);
        check("R3 irq at threshold", int'(blk_irq), 1);

        // R9: read a block while the front-end keeps writing.
        for (int k = 0; k < BLOCK_LEN; k++) begin cyc(1, 8'(n), 8'(~n), 1, 0); n++; end
        cyc(0, 0, 0, 0, 0);
        check("R9 count during service", int'(fill_level), BLOCK_LEN);

        // R3: drain, the interrupt drops below the threshold.
        for (int k = 0; k < BLOCK_LEN; k++) cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0);
        check("R3 irq after drain", int'(blk_irq), 0);

        // R5: fill to full, then write past full.
        for (int k = 0; k < DEPTH; k++) begin cyc(1, 8'(n), 8'(8'h3C ^ n), 0, 0); n++; end
        cyc(1, 8'hEE, 8'hEE, 0, 0);
        check("R5 full count", int'(fill_level), DEPTH);
        // R6: a new overrun in the same cycle as the clear keeps the flag.
        cyc(1, 8'hDD, 8'hDD, 0, 1);
        cyc(0, 0, 0, 0, 1);
        check("R6 overrun cleared", int'(overrun), 0);
        // R5: write and read together when full: write dropped, read accepted.
        cyc(1, 8'hCC, 8'hCC, 1, 0);

        // R4: drain everything across the wrap, then one empty read (R7).
        for (int k = 0; k < DEPTH; k++) cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0);
        check("R7 underflow set", int'(underflow), 1);
        check("R7 count stays zero", int'(fill_level), 0);
        cyc(0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0);
        check("R6 underflow cleared", int'(underflow), 0);
        check("R4 scoreboard drained", exp_q.size(), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule